// File: doc/BRIEF.md
# Alias-Safe Tag Controller for a Virtually-Indexed, Physically-Tagged Cache

This block holds the tag state and control for a two-way, 64-byte-line data cache. The set is chosen from virtual address bits while the TLB translates, and hits are decided on physical tags. With the default sizes (256 sets), the set index reaches two bits above the 4 KB page offset. Because of this, one physical line could land in any of four sets, one for each value of those two bits. The controller keeps at most one copy of a physical line in the whole array.

A request carries the virtual set index, the translated physical tag (physical address bits from the page boundary up) and a write flag. On a hit the controller answers at once and does no alias search. On a miss it raises `stall` and visits the other candidate sets one per cycle. It invalidates any copy of the missed line that it finds there. It then picks a victim in the target set and installs the new tag. An external snoop carries only a physical line address, so the controller checks every candidate set for it.

Each dirty line that is evicted or snooped leaves through a write-back request channel as a line address. This channel uses valid/ready: `wb_valid` and `wb_line` stay fixed until `wb_ready` is seen at a clock edge. While a write-back waits, the controller pauses its current walk and accepts no new request or snoop. Requests and snoops are accepted on valid and ready at the same edge. The response and snoop-done pulses last one cycle and cannot be back-pressured.

Top module: `vipt_alias_ctrl`

## Requirements
- R1: After reset every way is invalid, `req_ready` and `snp_ready` are 1, `stall` is 0 and the first lookup of any set misses.
- R2: A request hits when a valid way of set `req_vidx` holds a tag equal to `req_ptag`. `resp_valid` then pulses 2 cycles after acceptance, with `resp_hit`=1 and `resp_way` set to that way. No alias set is visited and no write-back is produced.
- R3: A miss that needs no alias write-back responds 2^AW+2 cycles after acceptance, where AW is the number of index bits above the page offset (4 alias sets give 6 cycles). `stall` is 1 from the second cycle after acceptance until the allocation completes, and no request or snoop is accepted while `stall` is 1.
- R4: On a miss, the controller visits the sets whose upper AW index bits equal the request's upper bits XOR k, for k=1..2^AW-1 in that order. The lower index bits stay the same. Any way there holding the missed tag is invalidated, so a later lookup through that alias set misses.
- R5: The victim is way 0 if it is invalid, else way 1 if it is invalid, else the way named by the set's replacement bit. Every hit or allocation sets that bit to the other way.
- R6: A write request marks its line dirty on a hit or an allocation. Every dirty line that is invalidated or evicted produces one write-back with line address {tag, lower index bits}. Alias write-backs come first, then the victim write-back. A clean line produces none.
- R7: `wb_valid` stays 1 with `wb_line` stable until `wb_ready`. While a write-back is pending, `req_ready` and `snp_ready` are 0.
- R8: A snoop of line address L visits the 2^AW sets formed from alias values 0,1,...,2^AW-1 above the lower index bits of L. It invalidates every way whose tag equals the upper bits of L and writes back the dirty ones. It then pulses `snp_done`, with `snp_hit`=1 if any copy was found. Without write-backs, the pulse comes 2^AW+1 cycles after acceptance, and it never coincides with `resp_valid`.
- R9: When a snoop and a request are both valid in an idle cycle, the snoop is taken first and the request waits.
- R10: On a miss, `resp_hit` is 0 and `resp_way` gives the way that was allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted at this edge if valid |
| req_vidx | input | IDX_W | Virtual set index |
| req_ptag | input | PA_W-PAGE_W | Translated physical tag |
| req_write | input | 1 | Request is a store (marks line dirty) |
| resp_valid | output | 1 | One-cycle lookup result pulse |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 1 | Hit way or allocated way |
| stall | output | 1 | Miss handling in progress |
| snp_valid | input | 1 | Snoop valid |
| snp_ready | output | 1 | Snoop accepted at this edge if valid |
| snp_line | input | PA_W-LINE_W | Snooped physical line address |
| snp_done | output | 1 | One-cycle snoop completion pulse |
| snp_hit | output | 1 | Snoop found a copy (valid with snp_done) |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Write-back request taken |
| wb_line | output | PA_W-LINE_W | Physical line address to write back |

## Verification
The bench builds the controller with PA_W=8, PAGE_W=4, LINE_W=2 and IDX_W=4. This gives 16 sets, four alias sets for every page-offset index and 4-bit tags. At this size the bench can sweep every set, every ordered pair of alias sets and every snoop line address, and a bench-side model predicts each hit, victim and write-back address. A second pass throttles `wb_ready` so that the walk pauses partway through, and a final case raises a snoop and a request together.

// File: rtl/vipt_alias_pkg.sv
package vipt_alias_pkg;
  localparam int WAYS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_PROBE,
    ST_ALLOC,
    ST_SNOOP
  } ctl_state_t;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 27
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [IDX_W-1:0]                   rd_set,
  output logic [vipt_alias_pkg::WAYS-1:0]    rd_valid,
  output logic [vipt_alias_pkg::WAYS-1:0]    rd_dirty,
  output logic [vipt_alias_pkg::WAYS-1:0][TAG_W-1:0] rd_tag,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_set,
  input  logic                               wr_way,
  input  logic                               wr_valid,
  input  logic                               wr_dirty,
  input  logic [TAG_W-1:0]                   wr_tag
);
  localparam int SETS = 1 << IDX_W;

  for (genvar w = 0; w < vipt_alias_pkg::WAYS; w++) begin : g_way
    logic [SETS-1:0]  val_q;
    logic [SETS-1:0]  dty_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             sel;

    assign sel = wr_en && (wr_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        dty_q <= '0;
      end else if (sel) begin
        val_q[wr_set] <= wr_valid;
        dty_q[wr_set] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) tag_q[wr_set] <= wr_tag;
    end

    assign rd_valid[w] = val_q[rd_set];
    assign rd_dirty[w] = dty_q[rd_set];
    assign rd_tag[w]   = tag_q[rd_set];
  end

  // An invalidated line must never be left marked dirty.
  assert_clean_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_valid) |-> !wr_dirty);
endmodule

// File: rtl/vipt_way_cmp.sv
module vipt_way_cmp #(
  parameter int TAG_W = 27
) (
  input  logic [vipt_alias_pkg::WAYS-1:0]            valid,
  input  logic [vipt_alias_pkg::WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]                           key,
  output logic [vipt_alias_pkg::WAYS-1:0]            match,
  output logic                                       any,
  output logic                                       idx
);
  for (genvar w = 0; w < vipt_alias_pkg::WAYS; w++) begin : g_cmp
    assign match[w] = valid[w] && (tags[w] == key);
  end

  assign any = |match;

  always_comb begin
    idx = 1'b0;
    for (int w = vipt_alias_pkg::WAYS - 1; w >= 0; w--) begin
      if (match[w]) idx = 1'(w);
    end
  end
endmodule

// File: rtl/vipt_lru.sv
module vipt_lru #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_set,
  output logic             rd_next,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_set,
  input  logic             upd_used
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      next_q <= '0;
    else if (upd_en) next_q[upd_set] <= ~upd_used;
  end

  assign rd_next = next_q[rd_set];
endmodule

// File: rtl/vipt_alias_ctrl.sv
module vipt_alias_ctrl #(
  parameter int PA_W   = 39,
  parameter int PAGE_W = 12,
  parameter int LINE_W = 6,
  parameter int IDX_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [IDX_W-1:0]          req_vidx,
  input  logic [PA_W-PAGE_W-1:0]    req_ptag,
  input  logic                      req_write,
  output logic                      resp_valid,
  output logic                      resp_hit,
  output logic                      resp_way,
  output logic                      stall,
  input  logic                      snp_valid,
  output logic                      snp_ready,
  input  logic [PA_W-LINE_W-1:0]    snp_line,
  output logic                      snp_done,
  output logic                      snp_hit,
  output logic                      wb_valid,
  input  logic                      wb_ready,
  output logic [PA_W-LINE_W-1:0]    wb_line
);
  import vipt_alias_pkg::*;

  localparam int TAG_W   = PA_W - PAGE_W;
  localparam int AW      = IDX_W + LINE_W - PAGE_W;
  localparam int LOW_W   = IDX_W - AW;
  localparam int LADDR_W = PA_W - LINE_W;

  ctl_state_t         state_q;
  logic [IDX_W-1:0]   set_q;
  logic [TAG_W-1:0]   ptag_q;
  logic               write_q;
  logic [AW-1:0]      cnt_q;
  logic               snp_hit_q;
  logic               snp_done_q;
  logic               resp_valid_q, resp_hit_q, resp_way_q;
  logic               wb_valid_q;
  logic [LADDR_W-1:0] wb_line_q;

  logic [IDX_W-1:0]   rd_set;
  logic [WAYS-1:0]    rd_valid, rd_dirty;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0]    way_match;
  logic               hit_any, hit_way;
  logic               lru_next, victim;
  logic               wb_free, last_set;
  logic [LOW_W-1:0]   low_q;

  logic               tw_en, tw_way, tw_valid, tw_dirty;
  logic [TAG_W-1:0]   tw_tag;
  logic               lru_en, lru_used;
  logic               wb_issue;
  logic [LADDR_W-1:0] wb_issue_line;

  assign low_q    = set_q[LOW_W-1:0];
  assign wb_free  = !wb_valid_q;
  assign last_set = &cnt_q;

  // Set being examined this cycle depends on the phase of the walk.
  always_comb begin
    unique case (state_q)
      ST_PROBE: rd_set = {set_q[IDX_W-1:LOW_W] ^ cnt_q, low_q};
      ST_SNOOP: rd_set = {cnt_q, low_q};
      default:  rd_set = set_q;
    endcase
  end

  vipt_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (rd_set),
    .rd_valid (rd_valid),
    .rd_dirty (rd_dirty),
    .rd_tag   (rd_tag),
    .wr_en    (tw_en),
    .wr_set   (rd_set),
    .wr_way   (tw_way),
    .wr_valid (tw_valid),
    .wr_dirty (tw_dirty),
    .wr_tag   (tw_tag)
  );

  vipt_way_cmp #(.TAG_W(TAG_W)) u_cmp (
    .valid (rd_valid),
    .tags  (rd_tag),
    .key   (ptag_q),
    .match (way_match),
    .any   (hit_any),
    .idx   (hit_way)
  );

  vipt_lru #(.IDX_W(IDX_W)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (rd_set),
    .rd_next  (lru_next),
    .upd_en   (lru_en),
    .upd_set  (rd_set),
    .upd_used (lru_used)
  );

  // Victim: first invalid way, otherwise the replacement bit.
  always_comb begin
    if (!rd_valid[0])      victim = 1'b0;
    else if (!rd_valid[1]) victim = 1'b1;
    else                   victim = lru_next;
  end

  // Array updates and write-back generation for the current phase.
  always_comb begin
    tw_en         = 1'b0;
    tw_way        = 1'b0;
    tw_valid      = 1'b0;
    tw_dirty      = 1'b0;
    tw_tag        = ptag_q;
    lru_en        = 1'b0;
    lru_used      = 1'b0;
    wb_issue      = 1'b0;
    wb_issue_line = {ptag_q, low_q};
    unique case (state_q)
      ST_LOOK: begin
        if (hit_any) begin
          tw_en    = 1'b1;
          tw_way   = hit_way;
          tw_valid = 1'b1;
          tw_dirty = rd_dirty[hit_way] | write_q;
          lru_en   = 1'b1;
          lru_used = hit_way;
        end
      end
      ST_PROBE, ST_SNOOP: begin
        if (wb_free && hit_any) begin
          tw_en    = 1'b1;
          tw_way   = hit_way;
          tw_tag   = rd_tag[hit_way];
          wb_issue = rd_dirty[hit_way];
        end
      end
      ST_ALLOC: begin
        if (wb_free) begin
          tw_en         = 1'b1;
          tw_way        = victim;
          tw_valid      = 1'b1;
          tw_dirty      = write_q;
          lru_en        = 1'b1;
          lru_used      = victim;
          wb_issue      = rd_valid[victim] && rd_dirty[victim];
          wb_issue_line = {rd_tag[victim], low_q};
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      set_q        <= '0;
      ptag_q       <= '0;
      write_q      <= 1'b0;
      cnt_q        <= '0;
      snp_hit_q    <= 1'b0;
      snp_done_q   <= 1'b0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_way_q   <= 1'b0;
      wb_valid_q   <= 1'b0;
      wb_line_q    <= '0;
    end else begin
      resp_valid_q <= 1'b0;
      snp_done_q   <= 1'b0;
      if (wb_valid_q && wb_ready) wb_valid_q <= 1'b0;
      if (wb_issue) begin
        wb_valid_q <= 1'b1;
        wb_line_q  <= wb_issue_line;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (snp_valid && wb_free) begin
            set_q     <= {{AW{1'b0}}, snp_line[LOW_W-1:0]};
            ptag_q    <= snp_line[LADDR_W-1:LOW_W];
            cnt_q     <= '0;
            snp_hit_q <= 1'b0;
            state_q   <= ST_SNOOP;
          end else if (req_valid && wb_free) begin
            set_q   <= req_vidx;
            ptag_q  <= req_ptag;
            write_q <= req_write;
            state_q <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit_any) begin
            resp_valid_q <= 1'b1;
            resp_hit_q   <= 1'b1;
            resp_way_q   <= hit_way;
            state_q      <= ST_IDLE;
          end else begin
            cnt_q   <= AW'(1);
            state_q <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          if (wb_free) begin
            if (last_set) state_q <= ST_ALLOC;
            else          cnt_q   <= cnt_q + AW'(1);
          end
        end
        ST_ALLOC: begin
          if (wb_free) begin
            resp_valid_q <= 1'b1;
            resp_hit_q   <= 1'b0;
            resp_way_q   <= victim;
            state_q      <= ST_IDLE;
          end
        end
        ST_SNOOP: begin
          if (wb_free) begin
            snp_hit_q <= snp_hit_q | hit_any;
            if (last_set) begin
              snp_done_q <= 1'b1;
              state_q    <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + AW'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE) && wb_free && !snp_valid;
  assign snp_ready  = (state_q == ST_IDLE) && wb_free;
  assign stall      = (state_q == ST_PROBE) || (state_q == ST_ALLOC);
  assign resp_valid = resp_valid_q;
  assign resp_hit   = resp_hit_q;
  assign resp_way   = resp_way_q;
  assign snp_done   = snp_done_q;
  assign snp_hit    = snp_hit_q;
  assign wb_valid   = wb_valid_q;
  assign wb_line    = wb_line_q;

  assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_line)));

  assert_wb_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (!req_ready && !snp_ready));

  assert_stall_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!req_ready && !snp_ready));

  assert_single_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(way_match) <= 1);

  assert_hit_no_search_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> $past(!stall));

  assert_done_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resp_valid, snp_done}));
endmodule

// File: tb/sim_vipt_alias_ctrl.sv
module sim_vipt_alias_ctrl;
  localparam int PA_W = 8, PAGE_W = 4, LINE_W = 2, IDX_W = 4;
  localparam int TAG_W = PA_W - PAGE_W;
  localparam int AW = IDX_W + LINE_W - PAGE_W;
  localparam int NAL = 1 << AW;
  localparam int NLOW = 1 << (IDX_W - AW);
  localparam int SETS = 1 << IDX_W;
  localparam int LADDR_W = PA_W - LINE_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, snp_valid = 0, wb_ready = 1;
  logic [IDX_W-1:0] req_vidx = '0;
  logic [TAG_W-1:0] req_ptag = '0;
  logic [LADDR_W-1:0] snp_line = '0;
  logic req_ready, resp_valid, resp_hit, resp_way, stall;
  logic snp_ready, snp_done, snp_hit, wb_valid;
  logic [LADDR_W-1:0] wb_line;

  always #10 clk = ~clk;

  vipt_alias_ctrl #(.PA_W(PA_W), .PAGE_W(PAGE_W), .LINE_W(LINE_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vidx(req_vidx),
    .req_ptag(req_ptag), .req_write(req_write),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .stall(stall),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_line(snp_line),
    .snp_done(snp_done), .snp_hit(snp_hit),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_line(wb_line)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit bp = 0;
  int got_wb [16];
  int got_n = 0;
  int exp_wb [16];
  int exp_n = 0, exp_probe = 0, exp_hit = 0, exp_way = 0;

  int  mtag [SETS][2];
  bit  mval [SETS][2];
  bit  mdty [SETS][2];
  int  mlru [SETS];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Write-back monitor: set ready for this cycle, then record a handshake.
  always @(negedge clk) begin
    cyc++;
    wb_ready = bp ? ((cyc % 3) == 0) : 1'b1;
    if (wb_valid && wb_ready && got_n < 16) begin
      got_wb[got_n] = int'(wb_line);
      got_n++;
    end
  end

  initial begin
    #(20 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic model_access(input int v, input int t, input bit w);
    int low = v % NLOW;
    int al = v / NLOW;
    int h = -1;
    exp_n = 0;
    for (int k = 0; k < 2; k++) if (mval[v][k] && mtag[v][k] == t) h = k;
    if (h >= 0) begin
      exp_hit = 1; exp_way = h; exp_probe = 0;
      mdty[v][h] = mdty[v][h] | w;
      mlru[v] = 1 - h;
    end else begin
      int vic;
      for (int c = 1; c < NAL; c++) begin
        int s = ((al ^ c) * NLOW) + low;
        for (int k = 0; k < 2; k++) if (mval[s][k] && mtag[s][k] == t) begin
          if (mdty[s][k]) begin exp_wb[exp_n] = t * NLOW + low; exp_n++; end
          mval[s][k] = 0; mdty[s][k] = 0;
        end
      end
      exp_probe = exp_n;
      if (!mval[v][0]) vic = 0;
      else if (!mval[v][1]) vic = 1;
      else vic = mlru[v];
      if (mval[v][vic] && mdty[v][vic]) begin
        exp_wb[exp_n] = mtag[v][vic] * NLOW + low; exp_n++;
      end
      mval[v][vic] = 1; mdty[v][vic] = w; mtag[v][vic] = t; mlru[v] = 1 - vic;
      exp_hit = 0; exp_way = vic;
    end
  endtask

  task automatic model_snoop(input int line, output int hit);
    int low = line % NLOW;
    int t = line / NLOW;
    hit = 0; exp_n = 0;
    for (int a = 0; a < NAL; a++) begin
      int s = a * NLOW + low;
      for (int k = 0; k < 2; k++) if (mval[s][k] && mtag[s][k] == t) begin
        hit = 1;
        if (mdty[s][k]) begin exp_wb[exp_n] = t * NLOW + low; exp_n++; end
        mval[s][k] = 0; mdty[s][k] = 0;
      end
    end
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 200 && !req_ready; g++) @(negedge clk);
  endtask

  task automatic compare_wb(input string req);
    check(got_n == exp_n, req, got_n, exp_n);
    if (got_n == exp_n)
      for (int i = 0; i < exp_n; i++) check(got_wb[i] == exp_wb[i], req, got_wb[i], exp_wb[i]);
  endtask

  task automatic do_req(input int v, input int t, input bit w);
    int lat = 0;
    bit seen = 0;
    wait_idle();
    model_access(v, t, w);
    got_n = 0;
    req_vidx = IDX_W'(v); req_ptag = TAG_W'(t); req_write = w; req_valid = 1;
    for (int i = 1; i < 200; i++) begin
      @(negedge clk);
      req_valid = 0;
      if (i == 2 && !bp) check(stall == !exp_hit, "R3 stall", int'(stall), int'(exp_hit == 0));
      if (resp_valid) begin lat = i; seen = 1; break; end
    end
    check(seen, "R2 response seen", int'(seen), 1);
    check(int'(resp_hit) == exp_hit, exp_hit ? "R2 hit" : "R1 miss", int'(resp_hit), exp_hit);
    check(int'(resp_way) == exp_way, exp_hit ? "R2 way" : "R10 R5 alloc way", int'(resp_way), exp_way);
    if (!bp && exp_hit) check(lat == 2, "R2 latency", lat, 2);
    if (!bp && !exp_hit && exp_probe == 0) check(lat == NAL + 2, "R3 latency", lat, NAL + 2);
    wait_idle();
    #1;
    compare_wb("R4 R6 write-back");
  endtask

  task automatic do_snoop(input int line);
    int eh, lat = 0;
    bit seen = 0;
    wait_idle();
    model_snoop(line, eh);
    got_n = 0;
    snp_line = LADDR_W'(line); snp_valid = 1;
    for (int i = 1; i < 200; i++) begin
      @(negedge clk);
      snp_valid = 0;
      if (snp_done) begin lat = i; seen = 1; break; end
    end
    check(seen, "R8 snoop done", int'(seen), 1);
    check(int'(snp_hit) == eh, "R8 snoop hit", int'(snp_hit), eh);
    if (!bp && exp_n == 0) check(lat == NAL + 1, "R8 latency", lat, NAL + 1);
    wait_idle();
    #1;
    compare_wb("R8 write-back");
  endtask

  initial begin
    int sh, t_snp, t_resp, rh, snh;
    bit acc;
    for (int s = 0; s < SETS; s++) begin
      mlru[s] = 0;
      for (int k = 0; k < 2; k++) begin mval[s][k] = 0; mdty[s][k] = 0; mtag[s][k] = 0; end
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R1 req_ready", int'(req_ready), 1);
    check(snp_ready == 1, "R1 snp_ready", int'(snp_ready), 1);
    check(stall == 0, "R1 stall", int'(stall), 0);
    check(wb_valid == 0, "R1 wb_valid", int'(wb_valid), 0);

    // R1 R2: fill every set, then hit each line.
    for (int v = 0; v < SETS; v++) do_req(v, (v * 5 + 3) % 16, v[0]);
    for (int v = 0; v < SETS; v++) do_req(v, (v * 5 + 3) % 16, 1'b0);

    // R4 R6: every ordered pair of alias sets for the same physical line.
    for (int lo = 0; lo < NLOW; lo++)
      for (int a1 = 0; a1 < NAL; a1++)
        for (int a2 = 0; a2 < NAL; a2++) if (a2 != a1) begin
          int t = (lo + a1 * 3 + a2) % 16;
          do_req(a1 * NLOW + lo, t, 1'b1);
          do_req(a2 * NLOW + lo, t, 1'b0);
          do_req(a1 * NLOW + lo, t, a2[0]);
        end

    // R5: replacement bit across three tags in one set.
    for (int r = 0; r < 12; r++) do_req(6, (r % 3) + 9, r[1]);
    do_req(6, 11, 1'b0);
    do_req(6, 9, 1'b1);
    do_req(6, 10, 1'b0);

    // R8: snoop every line address.
    for (int l = 0; l < (1 << LADDR_W); l++) do_snoop(l);
    for (int v = 0; v < SETS; v++) do_req(v, v, 1'b1);
    for (int l = 0; l < (1 << LADDR_W); l += 3) do_snoop(l);

    // R7: throttled write-back channel.
    bp = 1;
    for (int lo = 0; lo < NLOW; lo++)
      for (int a = 0; a < NAL; a++) begin
        do_req(a * NLOW + lo, 7, 1'b1);
        do_req(((a + 1) % NAL) * NLOW + lo, 7, 1'b1);
      end
    for (int l = 0; l < (1 << LADDR_W); l += 5) do_snoop(l);
    bp = 0;

    // R9: snoop and request raised together.
    do_req(5, 3, 1'b1);
    wait_idle();
    model_snoop(3 * NLOW + 1, sh);
    model_access(5, 3, 1'b0);
    t_snp = -1; t_resp = -1; rh = 1; snh = 0;
    snp_line = LADDR_W'(3 * NLOW + 1); snp_valid = 1;
    req_vidx = 4'd5; req_ptag = 4'd3; req_write = 0; req_valid = 1;
    @(negedge clk);
    snp_valid = 0;
    for (int i = 1; i < 200; i++) begin
      if (snp_done) begin t_snp = i; snh = int'(snp_hit); end
      if (resp_valid) begin t_resp = i; rh = int'(resp_hit); break; end
      acc = req_valid && req_ready;
      @(negedge clk);
      if (acc) req_valid = 0;
    end
    check(t_snp > 0 && t_resp > t_snp, "R9 snoop first", t_snp, t_resp);
    check(snh == sh, "R9 snoop hit", snh, sh);
    check(rh == 0, "R9 request misses after snoop", rh, 0);
    wait_idle();
    do_req(5, 3, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule